// File: doc/BRIEF.md
# Three-Operation Pipelined Core

This block is a minimal processor core with an 8-bit instruction word and three operations: put a small signed constant into a register, add one register into another, and XOR one register into another. A 16-word instruction store inside the block is filled through a write port. After reset the core fetches one word per cycle from an incrementing program counter. The counter wraps back to the first word, so the program repeats for as long as reset stays low.

Execution is split over two stages. The first stage fetches, decodes and reads both register operands. The second stage computes the result and writes it to one of eight 8-bit registers. Nothing bypasses the register file. An instruction that uses a register written by the instruction just ahead of it therefore sees the value from before that write. A result written two or more instructions earlier is seen normally. A flat debug output shows every register at all times, so a test environment can follow the program's effect.

Top module: `tc_core`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero and the program counter returns to word 0. The first instruction executed after release is the one stored at word 0.
- R2: A word with bit 7 = 0 is a constant move. Bits 6:3 hold a two's-complement 4-bit value, which is sign-extended to 8 bits and written into the register named by bits 2:0.
- R3: A word with bit 7 = 1 and bit 6 = 1 adds the register named by bits 5:3 into the register named by bits 2:0. The sum wraps modulo 256.
- R4: A word with bit 7 = 1 and bit 6 = 0 replaces the register named by bits 2:0 with its bitwise XOR with the register named by bits 5:3.
- R5: Operands are read one cycle before the preceding instruction's write lands. An instruction reading a register written by the instruction immediately before it receives the older value. An instruction two places later receives the new value.
- R6: After `rst` falls, the first result becomes visible on `dbg_regs` after the second rising edge. From then on, exactly one instruction's result lands per cycle.
- R7: The program counter advances by one each cycle and wraps from 15 to 0, so instruction number i executes the word at address i mod 16.
- R8: When `imem_we` is high at a rising edge, `imem_data` is stored at `imem_addr`. This is the case during reset as well. The stored words are kept across later resets.
- R9: Register n appears on `dbg_regs[8n+7:8n]`. A register changes only on the edge at which a result is written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 4 | Instruction store write address |
| imem_data | input | 8 | Instruction word to store |
| dbg_regs | output | 64 | All eight registers, register n in bits 8n+7:8n |

## Verification
The assertions assume that reset is asserted from time zero for at least one edge. They also assume the instruction store holds defined words before reset is released, because a partially loaded store would feed unknown values into the registers. The bench writes all sixteen words while reset is held, and it only releases reset once every word is written. It never writes the store while the core is running.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int INSTR_W  = 8;
  localparam int RIDX_W   = 3;
  localparam int NUM_REGS = 1 << RIDX_W;
  localparam int IMM_W    = 4;

  typedef enum logic [1:0] {
    OP_MOVI = 2'd0,
    OP_XOR  = 2'd1,
    OP_ADD  = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [IMM_W-1:0]  imm;
  } dec_t;

  // Field split of one instruction word; bit 7 and bit 6 pick the operation.
  function automatic dec_t split_word(logic [INSTR_W-1:0] w);
    dec_t d;
    if (!w[7])     d.op = OP_MOVI;
    else if (w[6]) d.op = OP_ADD;
    else           d.op = OP_XOR;
    d.rd  = w[2:0];
    d.rs  = w[5:3];
    d.imm = w[6:3];
    return d;
  endfunction
endpackage

// File: rtl/tc_fetch.sv
`timescale 1ns/1ps
module tc_fetch import tc_pkg::*; #(
  parameter int PC_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PC_W-1:0]    wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] word_o
);
  localparam int DEPTH = 1 << PC_W;

  logic [INSTR_W-1:0] store [DEPTH];
  logic [PC_W-1:0]    pc_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // No control transfer exists, so the counter only steps and wraps.
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end

  assign pc_o   = pc_q;
  assign word_o = store[pc_q];
endmodule

// File: rtl/tc_decode.sv
`timescale 1ns/1ps
module tc_decode import tc_pkg::*; (
  input  logic [INSTR_W-1:0] word_i,
  output dec_t               dec_o
);
  always_comb dec_o = split_word(word_i);
endmodule

// File: rtl/tc_regfile.sv
`timescale 1ns/1ps
module tc_regfile import tc_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [RIDX_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [RIDX_W-1:0]          raddr_a,
  input  logic [RIDX_W-1:0]          raddr_b,
  output logic [DATA_W-1:0]          rdata_a,
  output logic [DATA_W-1:0]          rdata_b,
  output logic [NUM_REGS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] cells [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                  q <= '0;
      else if (we && waddr == RIDX_W'(g))       q <= wdata;
    end
    assign cells[g] = q;
    assign flat_o[g*DATA_W +: DATA_W] = q;
  end

  // Plain reads: a write in the same cycle is not visible until after the edge.
  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/tc_execute.sv
`timescale 1ns/1ps
module tc_execute import tc_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] dst_val_i,
  input  logic [DATA_W-1:0] src_val_i,
  output logic              ex_valid_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] widen_imm(logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] compute(op_e op, logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b,
                                                logic [IMM_W-1:0] imm);
    case (op)
      OP_MOVI: return widen_imm(imm);
      OP_ADD:  return a + b;
      OP_XOR:  return a ^ b;
      default: return '0;
    endcase
  endfunction

  logic              vld_q;
  dec_t              dec_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dec_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      vld_q <= 1'b1;
      dec_q <= dec_i;
      a_q   <= dst_val_i;
      b_q   <= src_val_i;
    end
  end

  assign ex_valid_o = vld_q;
  assign wb_en_o    = vld_q;
  assign wb_addr_o  = dec_q.rd;
  assign wb_data_o  = compute(dec_q.op, a_q, b_q, dec_q.imm);
endmodule

// File: rtl/tc_core.sv
`timescale 1ns/1ps
module tc_core import tc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       imem_we,
  input  logic [PC_W-1:0]            imem_addr,
  input  logic [INSTR_W-1:0]         imem_data,
  output logic [NUM_REGS*DATA_W-1:0] dbg_regs
);
  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] fetch_word;
  dec_t               fetch_dec;
  logic [DATA_W-1:0]  rd_val;
  logic [DATA_W-1:0]  rs_val;
  logic               ex_valid;
  logic               wb_en;
  logic [RIDX_W-1:0]  wb_addr;
  logic [DATA_W-1:0]  wb_data;

  tc_fetch #(.PC_W(PC_W)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (imem_we),
    .wr_addr (imem_addr),
    .wr_data (imem_data),
    .pc_o    (pc),
    .word_o  (fetch_word)
  );

  tc_decode u_decode (
    .word_i (fetch_word),
    .dec_o  (fetch_dec)
  );

  tc_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (fetch_dec.rd),
    .raddr_b (fetch_dec.rs),
    .rdata_a (rd_val),
    .rdata_b (rs_val),
    .flat_o  (dbg_regs)
  );

  tc_execute #(.DATA_W(DATA_W)) u_exec (
    .clk        (clk),
    .rst        (rst),
    .dec_i      (fetch_dec),
    .dst_val_i  (rd_val),
    .src_val_i  (rs_val),
    .ex_valid_o (ex_valid),
    .wb_en_o    (wb_en),
    .wb_addr_o  (wb_addr),
    .wb_data_o  (wb_data)
  );
endmodule

// File: rtl/tc_core_checker.sv
`timescale 1ns/1ps
module tc_core_checker import tc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [PC_W-1:0]            pc,
  input logic                       ex_valid,
  input logic                       wb_en,
  input logic [RIDX_W-1:0]          wb_addr,
  input logic [DATA_W-1:0]          wb_data,
  input logic [NUM_REGS*DATA_W-1:0] dbg_regs
);
  logic              seen_en;
  logic [RIDX_W-1:0] seen_addr;
  logic [DATA_W-1:0] seen_data;

  always_ff @(posedge clk) begin
    if (rst) seen_en <= 1'b0;
    else     seen_en <= wb_en;
    seen_addr <= wb_addr;
    seen_data <= wb_data;
  end

  AST_RESET_CLEARS_REGS: assert property (@(posedge clk)
    rst |=> dbg_regs == '0); // R1
  AST_RESET_HOMES_PC: assert property (@(posedge clk)
    rst |=> pc == '0); // R1
  AST_PC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    pc == '1 |=> pc == '0); // R7
  AST_PC_RISES: assert property (@(posedge clk) disable iff (rst)
    pc != '1 |=> pc > $past(pc)); // R7
  AST_PIPE_FILLS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ex_valid); // R6
  AST_RESULT_LANDS: assert property (@(posedge clk) disable iff (rst)
    seen_en |-> dbg_regs[seen_addr*DATA_W +: DATA_W] == seen_data); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> $stable(dbg_regs)); // R9
endmodule

bind tc_core tc_core_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc),
  .ex_valid (ex_valid),
  .wb_en    (wb_en),
  .wb_addr  (wb_addr),
  .wb_data  (wb_data),
  .dbg_regs (dbg_regs)
);

// File: tb/tc_core_bench.sv
`timescale 1ns/1ps
module tc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [3:0]  imem_addr = '0;
  logic [7:0]  imem_data = '0;
  logic [63:0] dbg_regs;

  int checks = 0;
  int fails  = 0;
  logic [7:0] prog [16];
  logic [15:0] lfsr = 16'hACE1;

  tc_core u_tc_core (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_data(imem_data), .dbg_regs(dbg_regs)
  );

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete (got hang, expected finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [7:0] mv(int imm, int rd);
    return {1'b0, 4'(imm), 3'(rd)};
  endfunction
  function automatic logic [7:0] add(int rs, int rd);
    return {2'b11, 3'(rs), 3'(rd)};
  endfunction
  function automatic logic [7:0] xr(int rs, int rd);
    return {2'b10, 3'(rs), 3'(rd)};
  endfunction

  // Instruction meaning restated arithmetically from R2, R3, R4.
  function automatic logic [7:0] isa_result(logic [7:0] w, logic [7:0] d, logic [7:0] s);
    int v;
    if (w[7] == 1'b0) begin
      v = int'(w[6:3]);
      if (v > 7) v = v - 16;
      return 8'(v + 256);
    end else if (w[6]) begin
      v = (int'(d) + int'(s)) % 256;
      return 8'(v);
    end
    return d ^ s;
  endfunction

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0] ^ lfsr[15:8];
  endfunction

  task automatic check_regs(input logic [63:0] exp, input string tag, input int cyc);
    checks++;
    if (dbg_regs !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, dbg_regs, exp);
    end
  endtask

  // R8: words written while reset is held.
  task automatic load_prog();
    for (int i = 0; i < 16; i++) begin
      imem_we = 1'b1; imem_addr = 4'(i); imem_data = prog[i];
      @(posedge clk); @(negedge clk);
    end
    imem_we = 1'b0;
  endtask

  // Releases reset, follows the program for ncyc edges, then resets again.
  task automatic run_prog(input string tag, input int ncyc);
    logic [7:0]  cur [8];
    logic [7:0]  old [8];
    logic [7:0]  nw  [8];
    logic [63:0] flat;
    logic [7:0]  w;
    for (int j = 0; j < 8; j++) begin cur[j] = '0; old[j] = '0; end
    check_regs('0, "R1 registers cleared by reset", 0);
    rst = 1'b0;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= 2) begin
        // R5 and R7: instruction k-2 uses word (k-2) mod 16 and state before its predecessor wrote.
        w = prog[(k - 2) % 16];
        for (int j = 0; j < 8; j++) nw[j] = cur[j];
        nw[w[2:0]] = isa_result(w, old[w[2:0]], old[w[5:3]]);
        for (int j = 0; j < 8; j++) begin old[j] = cur[j]; cur[j] = nw[j]; end
      end
      for (int j = 0; j < 8; j++) flat[j*8 +: 8] = cur[j];
      // R9: register n at bits 8n+7:8n, compared every cycle.
      check_regs(flat, (k <= 2) ? "R6 first result timing" : tag, k);
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check_regs('0, "R1 reset state", 0);

    // R2: every immediate value, every destination.
    for (int i = 0; i < 16; i++) prog[i] = mv(i, i % 8);
    load_prog();
    run_prog("R2 sign-extended move sweep", 19);

    // R5 and R3: back-to-back dependencies and wrapping sums.
    prog[0]  = mv(3, 1);   prog[1]  = mv(5, 2);   prog[2]  = add(2, 1);
    prog[3]  = add(1, 2);  prog[4]  = add(1, 1);  prog[5]  = mv(7, 3);
    prog[6]  = mv(15, 4);  prog[7]  = add(3, 3);  prog[8]  = add(4, 3);
    prog[9]  = add(3, 4);  prog[10] = mv(8, 5);   prog[11] = add(5, 5);
    prog[12] = add(5, 5);  prog[13] = add(3, 5);  prog[14] = add(5, 6);
    prog[15] = add(6, 6);
    load_prog();
    run_prog("R5 stale operand and R3 wrapping add", 20);

    // R4: XOR chains including self-XOR.
    prog[0]  = mv(6, 0);   prog[1]  = mv(9, 1);   prog[2]  = xr(1, 0);
    prog[3]  = xr(0, 1);   prog[4]  = xr(0, 0);   prog[5]  = mv(-1, 2);
    prog[6]  = mv(4, 7);   prog[7]  = xr(7, 2);   prog[8]  = xr(2, 7);
    prog[9]  = xr(2, 2);   prog[10] = xr(1, 3);   prog[11] = xr(3, 3);
    prog[12] = add(2, 7);  prog[13] = xr(7, 6);   prog[14] = xr(6, 5);
    prog[15] = xr(5, 4);
    load_prog();
    run_prog("R4 xor program", 20);

    // R7 and R3/R4: random programs running several laps of the store.
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 16; i++) prog[i] = next_rand();
      load_prog();
      run_prog("R7 wrap with random program", 50);
    end

    // R1 and R8: reset mid-run, store kept, restart from word 0.
    for (int i = 0; i < 16; i++) prog[i] = next_rand();
    load_prog();
    run_prog("R8 program before reset", 23);
    run_prog("R1 restart from word 0 with kept store", 23);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule